// File: doc/BRIEF.md
# Flyback Switching Cycle Timer

This block sets the timing of every switching cycle of a primary-side regulated flyback power switch. It raises the gate and keeps the current-sense comparator masked for a blanking interval after turn-on. The gate then falls on the first unmasked sense trip, or when the on-time limit is reached. After turn-off it counts how long the secondary rectifier conducts, using a level input that stays high until the feedback knee.

During conduction it emits a one-cycle sample strobe, which the voltage loop uses to capture the reflected output. The strobe sits at a fraction of the conduction time measured in the previous cycle. That fraction follows the load level: 50 % at light load, 80 % at heavy load, and a linear ramp in between. A turn-on request from the valley detector is accepted only inside a window that opens when conduction ends. If no cycle starts for a maximum off time, a pulse is forced. All times are counted in clock cycles and set by parameters.

Top module: `flyback_cycle_timer`

## Requirements
- R1: While `rst_n` is low, `gate` and `sample_stb` are low and `tons_meas` is 0. Release of `rst_n` passes through a two-stage synchronizer, so the logic starts counting at the second rising edge after release.
- R2: A sense trip is ignored until the gate has been high for BLANK_CYC clock cycles. With `cs_trip` high from the start of a pulse, the gate stays high for exactly BLANK_CYC+1 cycles.
- R3: When the first `cs_trip` sample falls in the N-th gate-high cycle (counted from 1), with N > BLANK_CYC, the gate is high for exactly N cycles.
- R4: Without a sense trip, the gate falls after exactly MAX_ON_CYC high cycles.
- R5: `tons_meas` becomes the number of cycles `sec_cond` was sampled high after turn-off, updated on the first low sample after that. It does not change while the gate is high.
- R6: Conduction cycles are indexed from 0. `sample_stb` is high for one cycle right after the index P = floor(Tprev·Q / 1024). Tprev is `tons_meas` at turn-on, and Q is taken at the turn-on edge. There is no strobe if the conduction is shorter than P+1 cycles.
- R7: Q is 512 for `load_lvl` ≤ 2 and 819 for `load_lvl` ≥ 40, codes above 100 included. In between, Q = 512 + floor((load_lvl−2)·2070 / 256).
- R8: A `ton_req` is accepted when it is sampled within VALLEY_WIN_CYC cycles after conduction ends. The sample taken in the cycle right after the end counts as offset 0. The gate rises one cycle after an accepted request.
- R9: A `ton_req` sampled at offset VALLEY_WIN_CYC or later is ignored, and the gate stays low.
- R10: If no request is accepted, the gate rises after exactly MAX_OFF_CYC low cycles. From reset release this takes MAX_OFF_CYC+2 cycles, because of the synchronizer.
- R11: A `ton_req` during the on-time, during blanking, or before conduction has ended is ignored. It neither stretches nor restarts the pulse.
- R12: `sample_stb` is high only while the gate is low and `sec_cond` was high in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_trip | input | 1 | Current-sense comparator trip |
| sec_cond | input | 1 | High while the secondary rectifier conducts; falls at the knee |
| ton_req | input | 1 | Turn-on request from the valley detector |
| load_lvl | input | LOAD_W | Load level code, 0 to 100 percent |
| gate | output | 1 | Power switch gate drive |
| sample_stb | output | 1 | One-cycle output voltage sample strobe |
| tons_meas | output | TONS_W | Last measured conduction time in cycles |

## Verification
The bound checker watches every cycle for the pulse-width bounds: no gate pulse shorter than the blanking time plus one cycle, none longer than the on-time limit, and no off-interval beyond the forced-pulse limit. It also checks that the strobe only appears after a conduction sample with the gate low, that it never lasts two cycles, and that the measured time holds still during the on-time. The exact timing can only be shown by the directed scenarios, because each depends on a value carried over from an earlier cycle or on a request arriving at a chosen offset. These are the strobe position under each load segment, the acceptance edge of the valley window, and the ignoring of early or late requests.

// File: rtl/fct_pkg.sv
package fct_pkg;

  typedef enum logic [1:0] {
    PH_ON   = 2'd0,
    PH_COND = 2'd1,
    PH_IDLE = 2'd2
  } phase_e;

  // Sample ratio in units of 1/1024 of the conduction time
  localparam int RATIO_FRAC  = 10;
  localparam int RATIO_LOW   = 512;
  localparam int RATIO_HIGH  = 819;
  localparam int LOAD_KNEE_L = 2;
  localparam int LOAD_KNEE_H = 40;
  localparam int SLOPE_NUM   = 2070;
  localparam int SLOPE_SHIFT = 8;

endpackage

// File: rtl/fct_ratio_map.sv
module fct_ratio_map #(
  parameter int LOAD_W  = 7,
  parameter int RATIO_W = fct_pkg::RATIO_FRAC + 1,
  parameter int KNEE_L  = fct_pkg::LOAD_KNEE_L,
  parameter int KNEE_H  = fct_pkg::LOAD_KNEE_H,
  parameter int R_LOW   = fct_pkg::RATIO_LOW,
  parameter int R_HIGH  = fct_pkg::RATIO_HIGH,
  parameter int SLOPE   = fct_pkg::SLOPE_NUM,
  parameter int SHIFT   = fct_pkg::SLOPE_SHIFT
) (
  input  logic [LOAD_W-1:0]  load_lvl,
  output logic [RATIO_W-1:0] ratio
);

  localparam int PROD_W = LOAD_W + $clog2(SLOPE + 1);

  logic [PROD_W-1:0] ramp_prod;

  assign ramp_prod = PROD_W'(load_lvl - LOAD_W'(KNEE_L)) * PROD_W'(SLOPE);

  always_comb begin
    if (load_lvl <= LOAD_W'(KNEE_L)) begin
      ratio = RATIO_W'(R_LOW);
    end else if (load_lvl >= LOAD_W'(KNEE_H)) begin
      ratio = RATIO_W'(R_HIGH);
    end else begin
      ratio = RATIO_W'(R_LOW) + RATIO_W'(ramp_prod >> SHIFT);
    end
  end

endmodule

// File: rtl/fct_on_timer.sv
module fct_on_timer #(
  parameter int BLANK_CYC  = 94,
  parameter int MAX_ON_CYC = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_en,
  input  logic cs_trip,
  output logic on_end
);

  localparam int CW = $clog2(MAX_ON_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          blank_act;
  logic          cap_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (!on_en) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(MAX_ON_CYC)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign blank_act = (cnt_q < CW'(BLANK_CYC));
  assign cap_hit   = (cnt_q == CW'(MAX_ON_CYC - 1));
  assign on_end    = on_en && ((!blank_act && cs_trip) || cap_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fct_cond_meas.sv
module fct_cond_meas #(
  parameter int TONS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_en,
  input  logic              abort,
  input  logic              sec_cond,
  input  logic [TONS_W:0]   samp_pt,
  output logic              cond_done,
  output logic [TONS_W-1:0] tons_q,
  output logic              stb_q
);

  logic [TONS_W-1:0] cnt_q, cnt_d;
  logic              seen_q, seen_d;
  logic [TONS_W-1:0] tons_d;
  logic              stb_d;

  always_comb begin
    cnt_d     = cnt_q;
    seen_d    = seen_q;
    tons_d    = tons_q;
    stb_d     = 1'b0;
    cond_done = 1'b0;
    if (!meas_en) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (sec_cond) begin
      seen_d = 1'b1;
      if (cnt_q != '1) begin
        cnt_d = cnt_q + 1'b1;
      end
      stb_d = ({1'b0, cnt_q} == samp_pt) && !abort;
    end else if (seen_q) begin
      cond_done = 1'b1;
      tons_d    = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      tons_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      tons_q <= tons_d;
      stb_q  <= stb_d;
    end
  end

endmodule

// File: rtl/fct_off_timer.sv
module fct_off_timer #(
  parameter int VALLEY_WIN_CYC = 6400,
  parameter int MAX_OFF_CYC    = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_en,
  input  logic win_open,
  input  logic idle_ph,
  input  logic ton_req,
  output logic start_on
);

  localparam int OW = $clog2(MAX_OFF_CYC + 1);
  localparam int WW = $clog2(VALLEY_WIN_CYC + 1);

  logic [OW-1:0] off_q, off_d;
  logic [WW-1:0] win_q, win_d;
  logic          force_on;
  logic          valley_ok;

  always_comb begin
    off_d = off_q;
    if (!off_en) begin
      off_d = '0;
    end else if (off_q != OW'(MAX_OFF_CYC - 1)) begin
      off_d = off_q + 1'b1;
    end
  end

  always_comb begin
    win_d = win_q;
    if (win_open) begin
      win_d = '0;
    end else if (win_q < WW'(VALLEY_WIN_CYC)) begin
      win_d = win_q + 1'b1;
    end
  end

  assign force_on  = off_en && (off_q == OW'(MAX_OFF_CYC - 1));
  assign valley_ok = idle_ph && ton_req && (win_q < WW'(VALLEY_WIN_CYC));
  assign start_on  = force_on || valley_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      win_q <= WW'(VALLEY_WIN_CYC);
    end else begin
      off_q <= off_d;
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/flyback_cycle_timer.sv
module flyback_cycle_timer #(
  parameter int BLANK_CYC      = 94,
  parameter int MAX_ON_CYC     = 3200,
  parameter int VALLEY_WIN_CYC = 6400,
  parameter int MAX_OFF_CYC    = 400000,
  parameter int TONS_W         = 16,
  parameter int LOAD_W         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_trip,
  input  logic              sec_cond,
  input  logic              ton_req,
  input  logic [LOAD_W-1:0] load_lvl,
  output logic              gate,
  output logic              sample_stb,
  output logic [TONS_W-1:0] tons_meas
);

  import fct_pkg::*;

  localparam int RATIO_W = RATIO_FRAC + 1;
  localparam int PROD_W  = TONS_W + RATIO_W;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_e              phase_q, phase_d;
  logic                on_end;
  logic                cond_done;
  logic                start_on;
  logic [RATIO_W-1:0]  ratio;
  logic [PROD_W-1:0]   samp_prod;
  logic [TONS_W:0]     samp_new;
  logic [TONS_W:0]     samp_q, samp_d;
  logic                enter_on;

  fct_ratio_map #(
    .LOAD_W (LOAD_W),
    .RATIO_W(RATIO_W)
  ) u_ratio (
    .load_lvl(load_lvl),
    .ratio   (ratio)
  );

  fct_on_timer #(
    .BLANK_CYC (BLANK_CYC),
    .MAX_ON_CYC(MAX_ON_CYC)
  ) u_on (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .on_en  (phase_q == PH_ON),
    .cs_trip(cs_trip),
    .on_end (on_end)
  );

  fct_cond_meas #(
    .TONS_W(TONS_W)
  ) u_cond (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .meas_en  (phase_q == PH_COND),
    .abort    (start_on),
    .sec_cond (sec_cond),
    .samp_pt  (samp_q),
    .cond_done(cond_done),
    .tons_q   (tons_meas),
    .stb_q    (sample_stb)
  );

  fct_off_timer #(
    .VALLEY_WIN_CYC(VALLEY_WIN_CYC),
    .MAX_OFF_CYC   (MAX_OFF_CYC)
  ) u_off (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .off_en  (phase_q != PH_ON),
    .win_open(cond_done),
    .idle_ph (phase_q == PH_IDLE),
    .ton_req (ton_req),
    .start_on(start_on)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_ON:   if (on_end) phase_d = PH_COND;
      PH_COND: begin
        if (start_on)       phase_d = PH_ON;
        else if (cond_done) phase_d = PH_IDLE;
      end
      PH_IDLE: if (start_on) phase_d = PH_ON;
      default: phase_d = PH_IDLE;
    endcase
  end

  // Sample point for the coming cycle: previous conduction time times ratio
  assign samp_prod = PROD_W'(tons_meas) * PROD_W'(ratio);
  assign samp_new  = (TONS_W + 1)'(samp_prod >> RATIO_FRAC);
  assign enter_on  = (phase_d == PH_ON) && (phase_q != PH_ON);

  always_comb begin
    samp_d = samp_q;
    if (enter_on) begin
      samp_d = samp_new;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      samp_q  <= '0;
    end else begin
      phase_q <= phase_d;
      samp_q  <= samp_d;
    end
  end

  assign gate = (phase_q == PH_ON);

endmodule

// File: rtl/fct_timer_chk.sv
module fct_timer_chk #(
  parameter int BLANK_CYC   = 94,
  parameter int MAX_ON_CYC  = 3200,
  parameter int MAX_OFF_CYC = 400000,
  parameter int TONS_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate,
  input logic              sample_stb,
  input logic              sec_cond,
  input logic [TONS_W-1:0] tons_meas
);

  logic [31:0] hi_len, lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
      lo_len <= '0;
    end else begin
      hi_len <= gate ? hi_len + 1 : 32'd0;
      lo_len <= gate ? 32'd0 : lo_len + 1;
    end
  end

  assert_blank_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> (hi_len >= 32'(BLANK_CYC + 1)));

  assert_on_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> (hi_len <= 32'(MAX_ON_CYC)));

  assert_off_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (lo_len <= 32'(MAX_OFF_CYC)));

  assert_stb_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!gate && $past(sec_cond)));

  assert_stb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_tons_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> $stable(tons_meas));

endmodule

bind flyback_cycle_timer fct_timer_chk #(
  .BLANK_CYC  (BLANK_CYC),
  .MAX_ON_CYC (MAX_ON_CYC),
  .MAX_OFF_CYC(MAX_OFF_CYC),
  .TONS_W     (TONS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .gate      (gate),
  .sample_stb(sample_stb),
  .sec_cond  (sec_cond),
  .tons_meas (tons_meas)
);

// File: tb/sim_flyback_cycle_timer.sv
`timescale 1ns/1ps
module sim_flyback_cycle_timer;

  localparam int BLANK  = 6;
  localparam int MAXON  = 40;
  localparam int VWIN   = 30;
  localparam int MAXOFF = 200;
  localparam int TW     = 16;
  localparam int LW     = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_trip = 1'b0;
  logic          sec_cond = 1'b0;
  logic          ton_req = 1'b0;
  logic [LW-1:0] load_lvl = '0;
  logic          gate;
  logic          sample_stb;
  logic [TW-1:0] tons_meas;

  int n_chk = 0;
  int n_bad = 0;
  int lo_run = 0;
  int tons_prev = 0;
  int cur_samp = 0;

  flyback_cycle_timer #(
    .BLANK_CYC     (BLANK),
    .MAX_ON_CYC    (MAXON),
    .VALLEY_WIN_CYC(VWIN),
    .MAX_OFF_CYC   (MAXOFF),
    .TONS_W        (TW),
    .LOAD_W        (LW)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_trip   (cs_trip),
    .sec_cond  (sec_cond),
    .ton_req   (ton_req),
    .load_lvl  (load_lvl),
    .gate      (gate),
    .sample_stb(sample_stb),
    .tons_meas (tons_meas)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) lo_run <= gate ? 0 : lo_run + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int l);
    if (l <= 2) return 512;
    if (l >= 40) return 819;
    return 512 + ((l - 2) * 2070) / 256;
  endfunction

  function automatic int samp_of(input int t, input int l);
    return (t * ratio_of(l)) / 1024;
  endfunction

  task automatic wait_gate_high(output int lows);
    lows = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (gate) begin
        lows = lo_run;
        return;
      end
    end
  endtask

  // Called at the first negedge where the gate is seen high
  task automatic measure_on(input int trip_at, input string req, input int exp_w);
    int w;
    w = 1;
    if (trip_at == 1) cs_trip = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!gate) break;
      w++;
      if (w == trip_at) cs_trip = 1'b1;
    end
    cs_trip = 1'b0;
    chk(w == exp_w, req, w, exp_w);
  endtask

  // Called at the first negedge where the gate is seen low
  task automatic cond_run(input int t);
    int pos, nst, exp_pos;
    exp_pos = (cur_samp < t) ? cur_samp : -1;
    pos = -1;
    nst = 0;
    sec_cond = 1'b1;
    for (int m = 1; m <= t; m++) begin
      @(negedge clk);
      if (sample_stb) begin
        nst++;
        pos = m - 1;
      end
      if (m == t) sec_cond = 1'b0;
    end
    @(negedge clk);
    if (sample_stb) nst++;
    chk(pos == exp_pos, "R6,R7 strobe index", pos, exp_pos);
    chk(nst == ((exp_pos >= 0) ? 1 : 0), "R12 strobe count", nst, (exp_pos >= 0) ? 1 : 0);
    chk(tons_meas == TW'(t), "R5 conduction time", int'(tons_meas), t);
    tons_prev = t;
  endtask

  task automatic valley(input int d, input bit accept, input int load);
    int lows;
    load_lvl = LW'(load);
    cur_samp = samp_of(tons_prev, load);
    repeat (d) @(negedge clk);
    ton_req = 1'b1;
    @(negedge clk);
    ton_req = 1'b0;
    if (accept) begin
      chk(gate == 1'b1, "R8 request in window", int'(gate), 1);
    end else begin
      chk(gate == 1'b0, "R9 late request", int'(gate), 0);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(gate == 1'b0, "R9 gate stays low", int'(gate), 0);
      end
      wait_gate_high(lows);
      chk(lows == MAXOFF, "R10 forced after off limit", lows, MAXOFF);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(gate == 1'b0, "R1 gate in reset", int'(gate), 0);
      chk(sample_stb == 1'b0, "R1 strobe in reset", int'(sample_stb), 0);
    end
    chk(tons_meas == '0, "R1 tons in reset", int'(tons_meas), 0);
  endtask

  task automatic t_first_pulse;
    int n;
    rst_n = 1'b1;
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (gate) break;
      n++;
    end
    chk(n == MAXOFF + 2, "R10 first forced pulse", n, MAXOFF + 2);
    cur_samp = 0;
  endtask

  task automatic t_blank_and_ignore;
    ton_req = 1'b1;
    measure_on(1, "R2 trip held from start", BLANK + 1);
    for (int i = 0; i < 3; i++) begin
      chk(gate == 1'b0, "R11 request during pulse ignored", int'(gate), 0);
      @(negedge clk);
    end
    ton_req = 1'b0;
    cond_run(50);
    valley(0, 1'b1, 3);
  endtask

  task automatic t_late_trip;
    measure_on(BLANK + 5, "R3 trip after blanking", BLANK + 5);
    cond_run(60);
    valley(VWIN - 1, 1'b1, 21);
  endtask

  task automatic t_on_limit;
    measure_on(0, "R4 on-time limit", MAXON);
    cond_run(80);
    valley(VWIN, 1'b0, 127);
  endtask

  task automatic t_early_trip;
    measure_on(3, "R2 trip inside blanking", BLANK + 1);
    cond_run(100);
    valley(5, 1'b1, 40);
  endtask

  task automatic t_edge_trip;
    measure_on(BLANK + 1, "R3 trip at first unblanked cycle", BLANK + 1);
    cond_run(100);
    valley(1, 1'b1, 39);
  endtask

  task automatic t_short_cond;
    measure_on(BLANK + 2, "R3 trip two after blanking", BLANK + 2);
    cond_run(10);
    valley(2, 1'b1, 2);
  endtask

  task automatic t_final;
    measure_on(20, "R3 late trip", 20);
    cond_run(40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_first_pulse();
    t_blank_and_ignore();
    t_late_trip();
    t_on_limit();
    t_early_trip();
    t_edge_trip();
    t_short_cond();
    t_final();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule